// File: doc/BRIEF.md
# Floating-Point Issue Scoreboard

This block decides, in every cycle, whether the single floating-point instruction offered to it may start. Each operation class has a fixed result latency and a fixed initiation interval, and both can be long: a square root holds its unit for more than a hundred cycles. The block keeps one countdown per floating-point register and one countdown per operation unit. From these it raises `issue` when the candidate is free to go, or `stall` when it has to wait.

A candidate waits for three reasons. A source register may still be waiting for its result (read-after-write). The unit for the candidate's class may still be inside its initiation interval (structural). Or the destination may already have a write pending that would finish no earlier than the new one (write-after-write). The upstream stage keeps the candidate unchanged for as long as `stall` is high. When `issue` goes high, the countdowns are loaded at the next clock edge. The block does not perform the arithmetic.

Top module: `fp_issue_sb`

## Requirements
- R1: After reset all register and unit countdowns are zero. With `cand_valid` low, `issue` and `stall` are both low, and the first valid legal candidate issues at once.
- R2: `issue` and `stall` are combinational in the current candidate and state. `issue` = `cand_valid` and no hazard; `stall` = `cand_valid` and a hazard.
- R3: Operation codes on `cand_op`, given as latency/interval: 0 add or subtract (4/3), 1 multiply (8/4), 2 divide (36/35), 3 square root (112/111), 4 negate or absolute value (2/1), 5 compare (3/2). Codes 6 and 7 are reserved and never issue; they stall while valid.
- R4: A register written by an instruction that issues in cycle t can be read as source A by an instruction that issues no earlier than cycle t+latency.
- R5: Source B is checked for a read-after-write hazard only when `cand_use_b` is 1. Otherwise its pending state has no effect.
- R6: After an operation issues in cycle t, the next operation with the same code issues no earlier than cycle t+interval.
- R7: Different operation codes do not block each other structurally. Back-to-back issue of different classes is allowed.
- R8: A candidate stalls while its destination has a pending write whose remaining cycles are at least the candidate's own latency.
- R9: A stalled candidate leaves all countdowns unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | A candidate instruction is present |
| cand_op | input | 3 | Operation code (see R3) |
| cand_dst | input | 5 | Destination register |
| cand_src_a | input | 5 | First source register |
| cand_src_b | input | 5 | Second source register |
| cand_use_b | input | 1 | Second source is read |
| issue | output | 1 | Candidate starts this cycle |
| stall | output | 1 | Candidate must be held |

## Verification
The hardest case to reach is the write-after-write ordering rule. A short operation has to target a register that still has a long square-root or divide write pending. It also has to be held long enough for the remaining count to fall below its own latency, and this must happen while the long unit is still busy. The directed stimulus issues a square root and then, in the very next cycle, offers an add to the same destination with free sources. It checks that the add waits exactly 108 cycles. Random traffic over a small register set, with candidates held while stalled, then mixes all three hazards against a cycle-counting model.

// File: rtl/fpsb_pkg.sv
package fpsb_pkg;
    localparam int CNT_W = 7;
    localparam int OP_W  = 3;
    localparam int N_OPS = 2 ** OP_W;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_MUL  = 3'd1,
        OP_DIV  = 3'd2,
        OP_SQRT = 3'd3,
        OP_NEG  = 3'd4,
        OP_CMP  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } fp_op_e;

    function automatic logic op_legal(input logic [OP_W-1:0] op);
        return op <= OP_CMP;
    endfunction

    function automatic logic [CNT_W-1:0] op_lat(input logic [OP_W-1:0] op);
        case (op)
            OP_ADD:  return CNT_W'(4);
            OP_MUL:  return CNT_W'(8);
            OP_DIV:  return CNT_W'(36);
            OP_SQRT: return CNT_W'(112);
            OP_NEG:  return CNT_W'(2);
            OP_CMP:  return CNT_W'(3);
            default: return CNT_W'(1);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] op_ii(input logic [OP_W-1:0] op);
        case (op)
            OP_ADD:  return CNT_W'(3);
            OP_MUL:  return CNT_W'(4);
            OP_DIV:  return CNT_W'(35);
            OP_SQRT: return CNT_W'(111);
            OP_NEG:  return CNT_W'(1);
            OP_CMP:  return CNT_W'(2);
            default: return CNT_W'(1);
        endcase
    endfunction
endpackage

// File: rtl/fpsb_reg_timer.sv
module fpsb_reg_timer #(
    parameter int NREG = 32,
    parameter int CW   = fpsb_pkg::CNT_W,
    localparam int RW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [RW-1:0]            wr_dst,
    input  logic [CW-1:0]            wr_lat,
    output logic [NREG-1:0][CW-1:0]  cnt_o
);
    typedef struct packed {
        logic [NREG-1:0][CW-1:0] cnt;
    } rt_st_t;

    rt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_en && wr_dst == RW'(i))
                st_d.cnt[i] = wr_lat - CW'(1);
            else if (st_q.cnt[i] != '0)
                st_d.cnt[i] = st_q.cnt[i] - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_dst == RW'(g)) |=> st_q.cnt[g] == $past(wr_lat) - CW'(1));
        p_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!(wr_en && wr_dst == RW'(g)) && st_q.cnt[g] != '0)
                |=> st_q.cnt[g] == $past(st_q.cnt[g]) - CW'(1));
        p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!(wr_en && wr_dst == RW'(g)) && st_q.cnt[g] == '0) |=> st_q.cnt[g] == '0);
    end
endmodule

// File: rtl/fpsb_unit_timer.sv
module fpsb_unit_timer #(
    parameter int NU  = fpsb_pkg::N_OPS,
    parameter int CW  = fpsb_pkg::CNT_W,
    localparam int UW = $clog2(NU)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [UW-1:0]          start_unit,
    input  logic [CW-1:0]          start_ii,
    output logic [NU-1:0][CW-1:0]  cnt_o
);
    typedef struct packed {
        logic [NU-1:0][CW-1:0] cnt;
    } ut_st_t;

    ut_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int u = 0; u < NU; u++) begin
            if (start && start_unit == UW'(u))
                st_d.cnt[u] = start_ii - CW'(1);
            else if (st_q.cnt[u] != '0)
                st_d.cnt[u] = st_q.cnt[u] - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    for (genvar g = 0; g < NU; g++) begin : g_chk
        p_occupy_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (start && start_unit == UW'(g)) |=> st_q.cnt[g] == $past(start_ii) - CW'(1));
        p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!(start && start_unit == UW'(g)) && st_q.cnt[g] != '0)
                |=> st_q.cnt[g] == $past(st_q.cnt[g]) - CW'(1));
    end
endmodule

// File: rtl/fp_issue_sb.sv
module fp_issue_sb #(
    parameter int NREG = 32,
    localparam int RW  = $clog2(NREG),
    localparam int OW  = fpsb_pkg::OP_W,
    localparam int CW  = fpsb_pkg::CNT_W,
    localparam int NU  = fpsb_pkg::N_OPS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cand_valid,
    input  logic [OW-1:0] cand_op,
    input  logic [RW-1:0] cand_dst,
    input  logic [RW-1:0] cand_src_a,
    input  logic [RW-1:0] cand_src_b,
    input  logic          cand_use_b,
    output logic          issue,
    output logic          stall
);
    import fpsb_pkg::*;

    logic [NREG-1:0][CW-1:0] reg_cnt;
    logic [NU-1:0][CW-1:0]   unit_cnt;
    logic [CW-1:0]           lat, ii;
    logic                    raw_hz, struct_hz, waw_hz, bad_op, hazard;

    always_comb begin
        lat       = op_lat(cand_op);
        ii        = op_ii(cand_op);
        bad_op    = !op_legal(cand_op);
        raw_hz    = (reg_cnt[cand_src_a] != '0) ||
                    (cand_use_b && reg_cnt[cand_src_b] != '0);
        struct_hz = unit_cnt[cand_op] != '0;
        waw_hz    = reg_cnt[cand_dst] >= lat;
        hazard    = bad_op || raw_hz || struct_hz || waw_hz;
        issue     = cand_valid && !hazard;
        stall     = cand_valid && hazard;
    end

    fpsb_reg_timer #(.NREG(NREG), .CW(CW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (issue),
        .wr_dst (cand_dst),
        .wr_lat (lat),
        .cnt_o  (reg_cnt)
    );

    fpsb_unit_timer #(.NU(NU), .CW(CW)) u_units (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (issue),
        .start_unit (cand_op),
        .start_ii   (ii),
        .cnt_o      (unit_cnt)
    );

    p_src_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (reg_cnt[cand_src_a] == '0));
    p_src_b_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && cand_use_b) |-> (reg_cnt[cand_src_b] == '0));
    p_unit_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (unit_cnt[cand_op] == '0));
    p_waw_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (reg_cnt[cand_dst] < op_lat(cand_op)));
    p_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && cand_op > 3'd5) |-> !issue);
endmodule

// File: tb/fp_issue_sb_bench.sv
module fp_issue_sb_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cand_valid = 1'b0;
    logic [2:0] cand_op = '0;
    logic [4:0] cand_dst = '0, cand_src_a = '0, cand_src_b = '0;
    logic       cand_use_b = 1'b0;
    logic       issue, stall;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int rdy [32];
    int nxt [8];
    bit done = 0;

    always #4ns clk = ~clk;

    fp_issue_sb u_fp_issue_sb (
        .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_op(cand_op),
        .cand_dst(cand_dst), .cand_src_a(cand_src_a), .cand_src_b(cand_src_b),
        .cand_use_b(cand_use_b), .issue(issue), .stall(stall)
    );

    function automatic int m_lat(input int op);
        case (op)
            0: return 4;   1: return 8;   2: return 36;
            3: return 112; 4: return 2;   5: return 3;
            default: return 1;
        endcase
    endfunction

    function automatic int m_ii(input int op);
        case (op)
            0: return 3;   1: return 4;   2: return 35;
            3: return 111; 4: return 1;   5: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic bit m_ok(input int op, input int d, input int a, input int b, input bit ub);
        if (op > 5) return 0;
        if (rdy[a] > cyc) return 0;
        if (ub && rdy[b] > cyc) return 0;
        if (nxt[op] > cyc) return 0;
        if (rdy[d] - cyc >= m_lat(op)) return 0;
        return 1;
    endfunction

    task automatic check(input string tag, input logic got, input logic exp, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s cycle %0d: got %b expected %b", tag, what, cyc, got, exp);
        end
    endtask

    task automatic step(input bit v, input int op, input int d, input int a, input int b,
                        input bit ub, input string tag, output bit issued);
        bit e;
        @(negedge clk);
        cand_valid = v; cand_op = 3'(op); cand_dst = 5'(d);
        cand_src_a = 5'(a); cand_src_b = 5'(b); cand_use_b = ub;
        #1;
        e = v && m_ok(op, d, a, b, ub);
        check(tag, issue, e, "issue");
        check(tag, stall, v && !e, "stall");
        issued = issue;
        @(posedge clk);
        if (e) begin
            rdy[d] = cyc + m_lat(op);
            nxt[op] = cyc + m_ii(op);
        end
        cyc++;
    endtask

    task automatic idle(input int n);
        bit x;
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, "R2", x);
    endtask

    task automatic until_issue(input int op, input int d, input int a, input int b,
                               input bit ub, input string tag, output int stalls);
        bit got;
        stalls = 0;
        for (int k = 0; k < 300; k++) begin
            step(1, op, d, a, b, ub, tag, got);
            if (got) break;
            stalls++;
        end
    endtask

    task automatic expect_count(input string tag, input int got, input int exp, input string what);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    initial begin
        #(8ns * 190000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int s;
        bit got;
        int hold_op, hold_d, hold_a, hold_b;
        bit hold_ub, held;
        for (int i = 0; i < 32; i++) rdy[i] = 0;
        for (int i = 0; i < 8; i++) nxt[i] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: idle outputs after reset, then every legal class issues at once
        idle(2);
        step(1, 0, 1, 2, 3, 1, "R1", got); expect_count("R1", int'(got), 1, "first add issues");
        step(1, 1, 4, 5, 6, 1, "R7", got); expect_count("R7", int'(got), 1, "mul after add");
        step(1, 4, 7, 8, 9, 0, "R7", got); expect_count("R7", int'(got), 1, "neg after mul");
        idle(120);
        // R4 long: square root consumer waits 111 cycles
        until_issue(3, 1, 0, 0, 0, "R4", s);
        until_issue(4, 2, 1, 0, 0, "R4", s); expect_count("R4", s, 111, "sqrt consumer stalls");
        idle(120);
        // R6: second divide waits 34 cycles
        until_issue(2, 3, 0, 0, 0, "R6", s);
        until_issue(2, 4, 0, 0, 0, "R6", s); expect_count("R6", s, 34, "divide interval stalls");
        idle(60);
        until_issue(0, 5, 0, 0, 0, "R6", s);
        until_issue(0, 6, 0, 0, 0, "R6", s); expect_count("R6", s, 2, "add interval stalls");
        until_issue(4, 7, 0, 0, 0, "R6", s);
        until_issue(4, 8, 0, 0, 0, "R6", s); expect_count("R6", s, 0, "negate back to back");
        idle(20);
        // R4: multiply result consumed by multiply-free compare: 7 stalls
        until_issue(1, 9, 0, 0, 0, "R4", s);
        until_issue(5, 10, 9, 0, 0, "R4", s); expect_count("R4", s, 7, "mul consumer stalls");
        idle(20);
        // R5: pending source B ignored when unused, honoured when used
        until_issue(1, 11, 0, 0, 0, "R5", s);
        until_issue(0, 12, 0, 11, 0, "R5", s); expect_count("R5", s, 0, "unused src b");
        until_issue(5, 13, 0, 11, 1, "R5", s); expect_count("R5", s, 6, "used src b");
        idle(20);
        // R8: add behind square root to same destination waits 108 cycles
        until_issue(3, 14, 0, 0, 0, "R8", s);
        until_issue(0, 14, 0, 0, 0, "R8", s); expect_count("R8", s, 108, "waw stalls");
        idle(20);
        // R3: reserved codes never issue
        for (int i = 0; i < 4; i++) begin
            step(1, 6 + (i % 2), 15, 0, 0, 0, "R3", got);
            expect_count("R3", int'(got), 0, "reserved issue");
        end
        // R9: stalled multiply leaves its destination free
        until_issue(1, 16, 0, 0, 0, "R9", s);
        step(1, 1, 17, 0, 0, 0, "R9", got); expect_count("R9", int'(got), 0, "blocked mul");
        step(1, 4, 18, 17, 0, 0, "R9", got); expect_count("R9", int'(got), 1, "dst untouched by stall");
        idle(120);
        // R2: random traffic, candidate held while stalled
        held = 0;
        hold_op = 0; hold_d = 0; hold_a = 0; hold_b = 0; hold_ub = 0;
        for (int n = 0; n < 6000; n++) begin
            bit v;
            v = 1;
            if (!held) begin
                int r;
                r = int'($urandom_range(0, 99));
                hold_op = (r < 3) ? 3 : (r < 8) ? 2 : (r < 10) ? 6 : int'($urandom_range(0, 5));
                if (hold_op == 3 && $urandom_range(0, 1) == 1) hold_op = 4;
                hold_d = int'($urandom_range(0, 7));
                hold_a = int'($urandom_range(0, 7));
                hold_b = int'($urandom_range(0, 7));
                hold_ub = 1'($urandom_range(0, 1));
                v = ($urandom_range(0, 9) != 0);
                if (hold_op == 6) hold_op = 4;
            end
            step(v, hold_op, hold_d, hold_a, hold_b, hold_ub, "R2", got);
            held = v && !got;
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule